// File: doc/BRIEF.md
# Cascadable LCD Column Data Loader

This block gathers one display line of pixel bits (160 by default) from a shared parallel bus. The bus is either 4 or 8 bits wide, and it is sampled on each falling edge of a data clock. Each completed 8-bit group goes into a data latch. A direction pin sets whether the line fills from output 1 upward or from the last output downward.

Several loaders can share one bus. They are chained through their enable pins. A loader starts capturing when its enable input is low after a latch pulse, and it stops on its own after a full line. It then pulls its enable output low for one data-clock period, so the next loader in the chain takes the bus.

On the falling edge of the latch pulse, the whole data latch is copied into a line latch at once. Each line-latch bit, together with a frame-inversion input and a display-enable input, is turned into a 2-bit drive-level code for the output stage. All level inputs (data clock, latch pulse, enables) are sampled by the system clock. Edges take effect at the system-clock edge where the falling transition is first seen.

Top module: `lcd_line_loader`

## Requirements
- R1: In 8-bit mode with `fillFwd`=1, group g (0-based, in arrival order) is stored so that `dataIn[7]` lands on `lineBits[8g]` and `dataIn[0]` lands on `lineBits[8g+7]`. Output n corresponds to `lineBits[n-1]`.
- R2: In 8-bit mode with `fillFwd`=0, group g is stored so that `dataIn[0]` lands on `lineBits[152-8g]` and `dataIn[7]` lands on `lineBits[159-8g]`.
- R3: With `busWidth8`=0, only `dataIn[3:0]` is used. Two nibbles form one group: the first nibble is bits 7..4 and the second is bits 3..0. The group is then placed as in R1 or R2.
- R4: After a latch pulse, capture begins at the first data-clock fall that sees the enable input low. Capture then continues regardless of the enable input, until 20 groups are stored. Data-clock falls before the start, or after completion, change nothing.
- R5: `fillFwd`=1 makes EIO1 the enable input and EIO2 the output. `fillFwd`=0 reverses these roles. `eioNOutEn`=1 marks the output pin. The enable output is high except for the span from the fall that completes the line to the next data-clock fall, during which it is low. A pin in its input role drives 1 with its output enable at 0.
- R6: A latch-pulse falling edge copies the whole data latch into `lineBits` in one cycle. `lineBits` does not change otherwise, except for clearing under R7.
- R7: While `dispOn`=0, every code is 00 and `lineBits` is held at zero. A latch pulse transfers nothing, but the data latch still captures. After release, the old line latch stays cleared until the next latch pulse.
- R8: With `dispOn`=1, the code for output n is `driveCodes[2n-1:2n-2]` = {`frame`, NOT(`frame` XOR `lineBits[n-1]`)}. This gives 01 for frame 0 with data 0, 00 for frame 0 with data 1, 10 for frame 1 with data 0, and 11 for frame 1 with data 1 (00=lowest level, 11=highest).
- R9: A latch pulse before the line is complete still transfers the data latch. It restarts the group count and drops any half-received nibble, and the enable output never goes low.
- R10: After reset, `lineBits` is zero, both enable pins drive 1, and the codes follow R8 for an all-zero line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dataClk | input | 1 | Data clock; bus sampled on its falling edge |
| latchPulse | input | 1 | Line transfer on its falling edge |
| busWidth8 | input | 1 | 1 = 8-bit bus, 0 = 4-bit bus on bits 3..0 |
| fillFwd | input | 1 | 1 = fill upward from output 1, 0 = fill downward |
| dataIn | input | 8 | Parallel pixel data |
| dispOn | input | 1 | 0 = blank all outputs and clear line latch |
| frame | input | 1 | Frame inversion signal |
| eio1In | input | 1 | EIO1 pin, input side |
| eio2In | input | 1 | EIO2 pin, input side |
| eio1Out | output | 1 | EIO1 pin, driven value |
| eio1OutEn | output | 1 | EIO1 pin acts as output |
| eio2Out | output | 1 | EIO2 pin, driven value |
| eio2OutEn | output | 1 | EIO2 pin acts as output |
| lineBits | output | 160 | Line latch contents |
| driveCodes | output | 320 | 2-bit drive-level code per output |

## Verification
The embedded assertions check these on every cycle:
- the enable output stays low for no more than one data-clock period;
- completion happens only after the last group;
- a latch pulse restarts the count;
- the line latch clears under display-off and copies the data latch on transfer;
- every code is zero while the display is off.

Other behaviour needs the bench's scenarios. These are the bit placement for each bus width and direction, the refusal of data before selection and after completion, the blank span after display-off release, and the absence of an enable pulse on an early latch. For these, a behavioural model fed with the same stimulus is compared on every cycle.

// File: rtl/lcd_line_loader_pkg.sv
package lcd_line_loader_pkg;

  // Strobes issued by the control to the datapath in one system cycle.
  typedef struct packed {
    logic nibStore;  // hold the first nibble of a group
    logic groupWr;   // write one complete group into the data latch
    logic lineXfer;  // copy data latch into line latch
    logic lineClr;   // force line latch to zero
  } loadStrobe_t;

endpackage

// File: rtl/lcd_load_ctrl.sv
module lcd_load_ctrl
  import lcd_line_loader_pkg::*;
#(
  parameter int NUM_GROUPS = 20,
  parameter int GIDX_W     = $clog2(NUM_GROUPS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataClk,
  input  logic              latchPulse,
  input  logic              busWidth8,
  input  logic              enIn,
  input  logic              dispOn,
  output loadStrobe_t       strb,
  output logic [GIDX_W-1:0] groupIdx,
  output logic              enOutLow
);

  localparam logic [GIDX_W-1:0] LAST_GROUP = GIDX_W'(NUM_GROUPS - 1);

  logic dataClkQ, latchQ;
  logic active, done, eoLow, nibPhase;
  logic [GIDX_W-1:0] groupCnt;

  logic dataFall, latchFall, take, completes, lastGroup;

  assign dataFall  = dataClkQ & ~dataClk;
  assign latchFall = latchQ & ~latchPulse;
  assign take      = dataFall & ~latchFall & ~done & (active | ~enIn);
  assign completes = take & (busWidth8 | nibPhase);
  assign lastGroup = (groupCnt == LAST_GROUP);

  always_comb begin
    strb.nibStore = take & ~busWidth8 & ~nibPhase;
    strb.groupWr  = completes;
    strb.lineXfer = latchFall;
    strb.lineClr  = ~dispOn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataClkQ <= 1'b0;
      latchQ   <= 1'b0;
      active   <= 1'b0;
      done     <= 1'b0;
      eoLow    <= 1'b0;
      nibPhase <= 1'b0;
      groupCnt <= '0;
    end else begin
      dataClkQ <= dataClk;
      latchQ   <= latchPulse;
      if (latchFall) begin
        active   <= 1'b0;
        done     <= 1'b0;
        eoLow    <= 1'b0;
        nibPhase <= 1'b0;
        groupCnt <= '0;
      end else begin
        if (dataFall && eoLow) eoLow <= 1'b0;
        if (take) begin
          active   <= 1'b1;
          nibPhase <= busWidth8 ? 1'b0 : ~nibPhase;
        end
        if (completes) begin
          groupCnt <= groupCnt + GIDX_W'(1);
          if (lastGroup) begin
            done   <= 1'b1;
            active <= 1'b0;
            eoLow  <= 1'b1;
          end
        end
      end
    end
  end

  assign groupIdx = groupCnt;
  assign enOutLow = eoLow;

  // R5
  eo_single_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eoLow && dataFall) |=> !eoLow);

  // R4
  full_line_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(groupCnt) == LAST_GROUP));

  // R9
  latch_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    latchFall |=> (groupCnt == '0 && !eoLow && !active && !done));

endmodule

// File: rtl/lcd_load_datapath.sv
module lcd_load_datapath
  import lcd_line_loader_pkg::*;
#(
  parameter int NUM_OUT    = 160,
  parameter int GROUP_W    = 8,
  parameter int NUM_GROUPS = NUM_OUT / GROUP_W,
  parameter int GIDX_W     = $clog2(NUM_GROUPS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  loadStrobe_t        strb,
  input  logic [GIDX_W-1:0]  groupIdx,
  input  logic               fillFwd,
  input  logic               busWidth8,
  input  logic [GROUP_W-1:0] dataIn,
  output logic [NUM_OUT-1:0] lineBits
);

  localparam int HALF_W = GROUP_W / 2;

  logic [HALF_W-1:0]     nibHold;
  logic [GROUP_W-1:0]    groupIn, groupRev, slice;
  logic [NUM_GROUPS-1:0] slotHit;
  logic [NUM_OUT-1:0]    dataLatch, lineLatch;

  assign groupIn = busWidth8 ? dataIn : {nibHold, dataIn[HALF_W-1:0]};

  for (genvar j = 0; j < GROUP_W; j++) begin : g_rev
    assign groupRev[j] = groupIn[GROUP_W-1-j];
  end

  // Forward fill puts the MSB at the lowest output of the slot.
  assign slice = fillFwd ? groupRev : groupIn;

  for (genvar s = 0; s < NUM_GROUPS; s++) begin : g_slot
    localparam logic [GIDX_W-1:0] FWD_IDX = GIDX_W'(s);
    localparam logic [GIDX_W-1:0] REV_IDX = GIDX_W'(NUM_GROUPS - 1 - s);
    assign slotHit[s] = fillFwd ? (groupIdx == FWD_IDX) : (groupIdx == REV_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nibHold   <= '0;
      dataLatch <= '0;
    end else begin
      if (strb.nibStore) nibHold <= dataIn[HALF_W-1:0];
      for (int s = 0; s < NUM_GROUPS; s++) begin
        if (strb.groupWr && slotHit[s]) dataLatch[s*GROUP_W +: GROUP_W] <= slice;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              lineLatch <= '0;
    else if (strb.lineClr)  lineLatch <= '0;
    else if (strb.lineXfer) lineLatch <= dataLatch;
  end

  assign lineBits = lineLatch;

  // R7
  blank_clears_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.lineClr |=> (lineLatch == '0));

  // R6
  line_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lineXfer && !strb.lineClr) |=> (lineLatch == $past(dataLatch)));

  // R6
  line_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.lineXfer && !strb.lineClr) |=> $stable(lineLatch));

endmodule

// File: rtl/lcd_level_encoder.sv
module lcd_level_encoder #(
  parameter int NUM_OUT = 160
) (
  input  logic [NUM_OUT-1:0]   lineBits,
  input  logic                 frame,
  input  logic                 dispOn,
  output logic [2*NUM_OUT-1:0] codes
);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_code
    assign codes[2*i +: 2] = dispOn ? {frame, ~(frame ^ lineBits[i])} : 2'b00;
  end

endmodule

// File: rtl/lcd_line_loader.sv
module lcd_line_loader
  import lcd_line_loader_pkg::*;
#(
  parameter int NUM_OUT = 160,
  parameter int GROUP_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 dataClk,
  input  logic                 latchPulse,
  input  logic                 busWidth8,
  input  logic                 fillFwd,
  input  logic [GROUP_W-1:0]   dataIn,
  input  logic                 dispOn,
  input  logic                 frame,
  input  logic                 eio1In,
  input  logic                 eio2In,
  output logic                 eio1Out,
  output logic                 eio1OutEn,
  output logic                 eio2Out,
  output logic                 eio2OutEn,
  output logic [NUM_OUT-1:0]   lineBits,
  output logic [2*NUM_OUT-1:0] driveCodes
);

  localparam int NUM_GROUPS = NUM_OUT / GROUP_W;
  localparam int GIDX_W     = $clog2(NUM_GROUPS + 1);

  loadStrobe_t       strb;
  logic [GIDX_W-1:0] groupIdx;
  logic              enIn, enOutLow;

  assign enIn      = fillFwd ? eio1In : eio2In;
  assign eio1OutEn = ~fillFwd;
  assign eio2OutEn = fillFwd;
  assign eio1Out   = fillFwd ? 1'b1 : ~enOutLow;
  assign eio2Out   = fillFwd ? ~enOutLow : 1'b1;

  lcd_load_ctrl #(.NUM_GROUPS(NUM_GROUPS), .GIDX_W(GIDX_W)) i_ctrl (
    .clk, .rstN, .dataClk, .latchPulse, .busWidth8, .enIn, .dispOn,
    .strb, .groupIdx, .enOutLow
  );

  lcd_load_datapath #(.NUM_OUT(NUM_OUT), .GROUP_W(GROUP_W),
                      .NUM_GROUPS(NUM_GROUPS), .GIDX_W(GIDX_W)) i_dp (
    .clk, .rstN, .strb, .groupIdx, .fillFwd, .busWidth8, .dataIn, .lineBits
  );

  lcd_level_encoder #(.NUM_OUT(NUM_OUT)) i_enc (
    .lineBits, .frame, .dispOn, .codes(driveCodes)
  );

  // R7
  blank_codes_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dispOn |-> (driveCodes == '0));

endmodule

// File: tb/test_lcd_line_loader.sv
`timescale 1ns/1ps
module test_lcd_line_loader;

  logic clk = 1'b0, rstN = 1'b0;
  logic dataClk = 1'b0, latchPulse = 1'b0, busWidth8 = 1'b1, fillFwd = 1'b1;
  logic [7:0] dataIn = '0;
  logic dispOn = 1'b1, frame = 1'b0, eio1In = 1'b1, eio2In = 1'b1;
  logic eio1Out, eio1OutEn, eio2Out, eio2OutEn;
  logic [159:0] lineBits;
  logic [319:0] driveCodes;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lcd_line_loader i_lcd_line_loader (
    .clk, .rstN, .dataClk, .latchPulse, .busWidth8, .fillFwd, .dataIn,
    .dispOn, .frame, .eio1In, .eio2In, .eio1Out, .eio1OutEn, .eio2Out,
    .eio2OutEn, .lineBits, .driveCodes
  );

  // ---------------- behavioural reference model ----------------
  logic [159:0] mData = '0, mLine = '0;
  logic mPrevClk = 0, mPrevLat = 0, mAct = 0, mFin = 0, mEo = 0;
  int   mDone = 0;
  logic pend[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mData = '0; mLine = '0; mPrevClk = 0; mPrevLat = 0;
      mAct = 0; mFin = 0; mEo = 0; mDone = 0; pend.delete();
    end else begin
      logic dF, lF, ei;
      dF = mPrevClk && !dataClk;
      lF = mPrevLat && !latchPulse;
      mPrevClk = dataClk; mPrevLat = latchPulse;
      ei = fillFwd ? eio1In : eio2In;
      if (lF) begin
        if (dispOn) mLine = mData;
        pend.delete(); mDone = 0; mAct = 0; mFin = 0; mEo = 0;
      end else if (dF) begin
        if (mEo) mEo = 0;
        if (!mFin && (mAct || !ei)) begin
          mAct = 1;
          for (int k = (busWidth8 ? 7 : 3); k >= 0; k--) pend.push_back(dataIn[k]);
          if (pend.size() == 8) begin
            for (int j = 0; j < 8; j++) begin
              if (fillFwd) mData[mDone + j] = pend[j];
              else         mData[159 - mDone - j] = pend[j];
            end
            mDone += 8;
            pend.delete();
            if (mDone == 160) begin mFin = 1; mAct = 0; mEo = 1; end
          end
        end
      end
      if (!dispOn) mLine = '0;
    end
  end

  bit eoSeen = 0;

  // per-cycle comparison
  always @(negedge clk) begin
    #1;
    if (rstN && !finished) begin
      logic [319:0] expCodes;
      for (int i = 0; i < 160; i++)
        expCodes[2*i +: 2] = dispOn ? {frame, ~(frame ^ mLine[i])} : 2'b00;
      nChecks++;
      if (lineBits !== mLine) begin
        nFails++; $display("FAIL R6 lineBits act=%h exp=%h", lineBits, mLine);
      end
      nChecks++;
      if (driveCodes !== expCodes) begin
        nFails++; $display("FAIL R8 driveCodes act=%h exp=%h", driveCodes, expCodes);
      end
      nChecks++;
      if ({eio1Out, eio1OutEn, eio2Out, eio2OutEn} !==
          {(fillFwd ? 1'b1 : ~mEo), ~fillFwd, (fillFwd ? ~mEo : 1'b1), fillFwd}) begin
        nFails++;
        $display("FAIL R5 eio act=%b%b%b%b exp=%b%b%b%b", eio1Out, eio1OutEn, eio2Out, eio2OutEn,
                 (fillFwd ? 1'b1 : ~mEo), ~fillFwd, (fillFwd ? ~mEo : 1'b1), fillFwd);
      end
      if (!eio1Out || !eio2Out) eoSeen = 1;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string req, logic [319:0] act, logic [319:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++; $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] patByte(int line, int g);
    return 8'((g * 29 + line * 53 + 60) & 255);
  endfunction

  function automatic logic [159:0] fwdVec(int line, int ng, logic [159:0] base);
    logic [159:0] v = base;
    for (int g = 0; g < ng; g++)
      for (int j = 0; j < 8; j++) v[8*g + 7 - j] = patByte(line, g)[j];
    return v;
  endfunction

  function automatic logic [159:0] revVec(int line, int ng, logic [159:0] base);
    logic [159:0] v = base;
    for (int g = 0; g < ng; g++)
      for (int j = 0; j < 8; j++) v[152 - 8*g + j] = patByte(line, g)[j];
    return v;
  endfunction

  task automatic dataTick(logic [7:0] d);
    @(negedge clk); dataIn = d; dataClk = 1'b1;
    repeat (2) @(negedge clk);
    dataClk = 1'b0;
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic sendGroup(logic [7:0] b);
    if (busWidth8) dataTick(b);
    else begin
      dataTick({4'hF, b[7:4]});
      dataTick({4'hF, b[3:0]});
    end
  endtask

  task automatic sendLine(int line, int ng);
    for (int g = 0; g < ng; g++) sendGroup(patByte(line, g));
  endtask

  task automatic latchTick();
    @(negedge clk); latchPulse = 1'b1;
    repeat (2) @(negedge clk);
    latchPulse = 1'b0;
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog expired act=running exp=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [159:0] base;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk); #1;

    // R10 reset state
    chk("R10 lineBits", {160'b0, lineBits}, '0);
    chk("R10 codes", driveCodes, {160{2'b01}});
    chk("R10 eio", {316'b0, eio1Out, eio2Out, eio1OutEn, eio2OutEn}, {316'b0, 4'b1101});

    // R1, R4, R5: 8-bit forward, enable input EIO1 low, two surplus groups
    busWidth8 = 1; fillFwd = 1; eio1In = 0; eio2In = 1;
    sendLine(1, 19);
    chk("R5 idle high", {319'b0, eio2Out}, 320'd1);
    sendGroup(patByte(1, 19));
    chk("R5 enable out low", {319'b0, eio2Out}, 320'd0);
    sendGroup(8'hFF);
    chk("R5 enable out restored", {319'b0, eio2Out}, 320'd1);
    sendGroup(8'h00);
    chk("R6 no change before latch", {160'b0, lineBits}, '0);
    latchTick();
    chk("R1 fwd 8-bit / R4 surplus ignored", {160'b0, lineBits}, {160'b0, fwdVec(1, 20, '0)});

    // R2: 8-bit reverse, enable input EIO2 low
    fillFwd = 0; eio1In = 1; eio2In = 0;
    sendLine(2, 20);
    chk("R5 reverse output on EIO1", {318'b0, eio1Out, eio1OutEn}, {318'b0, 2'b01});
    sendGroup(8'h5A);
    latchTick();
    chk("R2 rev 8-bit", {160'b0, lineBits}, {160'b0, revVec(2, 20, '0)});

    // R3: 4-bit forward and reverse
    busWidth8 = 0; fillFwd = 1; eio1In = 0; eio2In = 1;
    sendLine(3, 20);
    latchTick();
    chk("R3 fwd 4-bit", {160'b0, lineBits}, {160'b0, fwdVec(3, 20, '0)});
    fillFwd = 0; eio1In = 1; eio2In = 0;
    sendLine(4, 20);
    latchTick();
    chk("R3 rev 4-bit", {160'b0, lineBits}, {160'b0, revVec(4, 20, '0)});

    // R4: enable input held high, nothing captured
    busWidth8 = 1; fillFwd = 1; eio1In = 1; eio2In = 1;
    sendLine(6, 5);
    latchTick();
    chk("R4 unselected ignores data", {160'b0, lineBits}, {160'b0, revVec(4, 20, '0)});

    // R4: start with enable low, then enable high, capture continues
    eio1In = 0;
    sendGroup(patByte(7, 0));
    eio1In = 1;
    for (int g = 1; g < 20; g++) sendGroup(patByte(7, g));
    latchTick();
    chk("R4 stays selected", {160'b0, lineBits}, {160'b0, fwdVec(7, 20, '0)});

    // R9: early latch, partial transfer, no enable pulse, half nibble dropped
    eio1In = 0; eoSeen = 0;
    sendLine(9, 7);
    busWidth8 = 0;
    dataTick(8'h0C);
    latchTick();
    base = fwdVec(9, 7, fwdVec(7, 20, '0));
    chk("R9 partial transfer", {160'b0, lineBits}, {160'b0, base});
    chk("R9 no enable pulse", {319'b0, eoSeen}, '0);
    busWidth8 = 1;
    sendLine(10, 20);
    latchTick();
    chk("R9 count restarted", {160'b0, lineBits}, {160'b0, fwdVec(10, 20, '0)});

    // R7: display off
    @(negedge clk); dispOn = 0;
    @(negedge clk); #1;
    chk("R7 codes blank", driveCodes, '0);
    chk("R7 line cleared", {160'b0, lineBits}, '0);
    sendLine(11, 20);
    latchTick();
    chk("R7 no transfer while off", {160'b0, lineBits}, '0);
    @(negedge clk); dispOn = 1;
    @(negedge clk); #1;
    chk("R7 cleared after release", {160'b0, lineBits}, '0);
    chk("R8 blank line codes frame0", driveCodes, {160{2'b01}});
    latchTick();
    chk("R7 capture kept while off", {160'b0, lineBits}, {160'b0, fwdVec(11, 20, '0)});

    // R8: code encoding for both frame phases
    begin
      logic [319:0] e0, e1;
      logic [159:0] v;
      v = fwdVec(11, 20, '0);
      for (int i = 0; i < 160; i++) begin
        e0[2*i +: 2] = v[i] ? 2'b00 : 2'b01;
        e1[2*i +: 2] = v[i] ? 2'b11 : 2'b10;
      end
      chk("R8 frame0 codes", driveCodes, e0);
      @(negedge clk); frame = 1; #1;
      chk("R8 frame1 codes", driveCodes, e1);
    end

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      summary();
      $finish;
    end
  end

endmodule